// File: doc/BRIEF.md
# Adaptive Request Priority Regulator

This block sits on a request channel between a requester and the interconnect and rewrites the 4-bit priority value carried by each request. Configuration inputs choose how the outgoing value is produced. It can forward the incoming value unchanged. It can substitute a programmed constant. Or it can drive a closed-loop regulator whose output follows how well the requester's traffic meets a cycle-count target.

In closed-loop operation the block keeps a fractional priority accumulator. Every cycle it moves the accumulator up, moves it down, or leaves it alone, by a step that is a programmable power of two. Two measures can drive the loop.

- **Latency measure:** an age counter follows the oldest outstanding transaction. When that transaction completes while others remain, the counter restarts from zero.
- **Period measure:** a counter holds the number of cycles since the last accepted request.

Both measures are compared with one shared target field. When the period measure is selected and nothing is outstanding, a sub-mode chooses between holding the priority and raising it.

Top module: `prio_regulator`

## Requirements
- R1: With `cfg_override_en` = 0, `req_prio_out` equals `req_prio_in` in the same cycle, whatever the other configuration inputs hold.
- R2: With `cfg_override_en` = 1 and `cfg_reg_en` = 0, `req_prio_out` equals `cfg_prog_prio`.
- R3: With `cfg_override_en` = 1 and `cfg_reg_en` = 1, `req_prio_out` is the integer part (upper 4 bits) of a 16-bit accumulator that has 4 integer bits and 12 fraction bits.
- R4: Latency measure (`cfg_period_mode` = 0), applied at each clock edge while at least one transaction is outstanding:
  - the accumulator rises by one step when the age of the oldest outstanding transaction exceeds `cfg_target`;
  - it falls by one step when the age is below `cfg_target`;
  - it holds when the age is equal to `cfg_target`.
  - The age is 0 in the first cycle a transaction is outstanding and grows by 1 each cycle after that.
  - When a completion arrives, the age restarts at 0.
- R5: Period measure (`cfg_period_mode` = 1), while at least one transaction is outstanding:
  - the accumulator rises by one step when the number of cycles since the last accepted request exceeds `cfg_target`;
  - it falls by one step when that count is below `cfg_target`;
  - it holds when the count is equal to `cfg_target`.
  - The gap count is 0 in the cycle after an accepted request.
- R6: With the period measure selected, `cfg_quiesce_high` = 0 and no transactions outstanding, the accumulator holds its value.
- R7: With the period measure selected, `cfg_quiesce_high` = 1 and no transactions outstanding, the accumulator rises by one step every cycle.
- R8: The step is 2^(`cfg_ki` − 12):
  - code 0 adds or removes one fraction LSB (2^-12);
  - code 7 adds or removes 2^-5, so 32 steps change the output by 1.
- R9: The accumulator saturates at 0 going down and at all ones (15 + 4095/4096) going up.
- R10: In the cycle after reset, and in any cycle after regulation was off (override or regulation disabled), the accumulator holds `cfg_prog_prio` with all fraction bits zero.
- R11: An accepted request (`req_valid` and `req_ready` both high) adds one to the outstanding count, and `rsp_done` removes one when the count is non-zero. With the latency measure and a count of zero, the accumulator holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request presented by the requester |
| req_ready | input | 1 | Request accepted by the interconnect |
| rsp_done | input | 1 | One transaction completes this cycle |
| req_prio_in | input | PRIO_W (4) | Priority supplied by the requester |
| cfg_override_en | input | 1 | Replace the incoming priority |
| cfg_reg_en | input | 1 | Use the regulated value when replacing |
| cfg_period_mode | input | 1 | 0 = latency measure, 1 = inter-issue period measure |
| cfg_quiesce_high | input | 1 | In period measure, raise the priority while idle |
| cfg_prog_prio | input | PRIO_W (4) | Programmed constant and accumulator start value |
| cfg_target | input | CNT_W (16) | Target latency or period, in cycles |
| cfg_ki | input | KI_W (3) | Step code, 2^(code−12) |
| req_prio_out | output | PRIO_W (4) | Priority sent toward the interconnect |

## Verification
Timing of the outputs:

- The rewritten priority depends on the current inputs through a multiplexer, so the same cycle that presents the inputs also shows the resulting `req_prio_out`.
- An adjustment decided in one cycle shows in the accumulator only after the next rising edge.
- Counter updates (outstanding count, age, gap) likewise show only after the next rising edge.

How the bench follows that timing:

- It drives the inputs just after the falling edge and compares `req_prio_out` 1 ns later against a reference model evaluated on those same inputs.
- It then advances the model by exactly one edge, so every expected value lines up with the edge that produces it.
- Directed scenarios end with endpoint checks placed many step-periods away from any threshold, so an off-by-one in age or gap counting shows up in the per-cycle compare and not as a fragile endpoint.

// File: rtl/prio_reg_pkg.sv
package prio_reg_pkg;

  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;

  // Compare a measured cycle count with the target.
  function automatic adj_e cmp_target(input logic [31:0] meas, input logic [31:0] tgt);
    if (meas > tgt)      return ADJ_UP;
    else if (meas < tgt) return ADJ_DOWN;
    else                 return ADJ_HOLD;
  endfunction

endpackage

// File: rtl/prio_outst_tracker.sv
module prio_outst_tracker #(
  parameter int OUTST_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue,
  input  logic               done,
  output logic               busy,
  output logic [CNT_W-1:0]   age
);
  localparam logic [OUTST_W-1:0] OMAX = {OUTST_W{1'b1}};
  localparam logic [CNT_W-1:0]   CMAX = {CNT_W{1'b1}};

  logic [OUTST_W-1:0] outst_q;
  logic [CNT_W-1:0]   age_q;
  logic               inc, dec;

  always_comb begin
    inc = issue && (outst_q != OMAX);
    dec = done && (outst_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outst_q <= '0;
      age_q   <= '0;
    end else begin
      outst_q <= outst_q + OUTST_W'(inc) - OUTST_W'(dec);
      if (dec || outst_q == '0)
        age_q <= '0;
      else if (age_q != CMAX)
        age_q <= age_q + 1'b1;
    end
  end

  assign busy = (outst_q != '0);
  assign age  = age_q;

  // R11: an accept without a completion grows the outstanding count by one
  p_outst_up_r11: assert property (@(posedge clk) disable iff (rst)
    (issue && !done && outst_q != OMAX) |=> (outst_q == $past(outst_q) + 1'b1));

  // R11: a completion without an accept shrinks a non-zero count by one
  p_outst_dn_r11: assert property (@(posedge clk) disable iff (rst)
    (!issue && done && outst_q != '0) |=> (outst_q == $past(outst_q) - 1'b1));

  // R4: age restarts after a completion
  p_age_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (done && busy) |=> (age_q == '0));

endmodule

// File: rtl/prio_gap_timer.sv
module prio_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  output logic [CNT_W-1:0] gap
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || issue)
      gap_q <= '0;
    else if (gap_q != CMAX)
      gap_q <= gap_q + 1'b1;
  end

  assign gap = gap_q;

  // R5: the gap count is zero in the cycle after an accept
  p_gap_clear_r5: assert property (@(posedge clk) disable iff (rst)
    issue |=> (gap_q == '0));

endmodule

// File: rtl/prio_accum.sv
module prio_accum
  import prio_reg_pkg::*;
#(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 12,
  parameter int KI_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  adj_e             adj,
  input  logic [KI_W-1:0]  ki,
  input  logic [INT_W-1:0] prog,
  output logic [INT_W-1:0] level
);
  localparam int ACC_W = INT_W + FRAC_W;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [ACC_W-1:0] acc_q, acc_d, step;

  always_comb begin
    step  = ACC_W'(1) << ki;
    acc_d = acc_q;
    if (!active) begin
      acc_d = {prog, {FRAC_W{1'b0}}};
    end else begin
      case (adj)
        ADJ_UP:   acc_d = (acc_q > ACC_MAX - step) ? ACC_MAX : acc_q + step;
        ADJ_DOWN: acc_d = (acc_q < step) ? '0 : acc_q - step;
        default:  acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= {prog, {FRAC_W{1'b0}}};
    else     acc_q <= acc_d;
  end

  assign level = acc_q[ACC_W-1:FRAC_W];

  // R10: while regulation is off the accumulator reloads the programmed value
  p_load_prog_r10: assert property (@(posedge clk) disable iff (rst)
    !active |=> (acc_q == {$past(prog), {FRAC_W{1'b0}}}));

  // R8: an unsaturated rise moves by exactly one step
  p_step_up_r8: assert property (@(posedge clk) disable iff (rst)
    (active && adj == ADJ_UP && acc_q <= ACC_MAX - step)
      |=> (acc_q == $past(acc_q) + $past(step)));

  // R9: saturation at the top
  p_sat_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (active && adj == ADJ_UP && acc_q == ACC_MAX) |=> (acc_q == ACC_MAX));

  // R9: saturation at the bottom
  p_sat_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (active && adj == ADJ_DOWN && acc_q == '0) |=> (acc_q == '0));

endmodule

// File: rtl/prio_regulator.sv
module prio_regulator
  import prio_reg_pkg::*;
#(
  parameter int PRIO_W  = 4,
  parameter int FRAC_W  = 12,
  parameter int KI_W    = 3,
  parameter int CNT_W   = 16,
  parameter int OUTST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_done,
  input  logic [PRIO_W-1:0] req_prio_in,
  input  logic              cfg_override_en,
  input  logic              cfg_reg_en,
  input  logic              cfg_period_mode,
  input  logic              cfg_quiesce_high,
  input  logic [PRIO_W-1:0] cfg_prog_prio,
  input  logic [CNT_W-1:0]  cfg_target,
  input  logic [KI_W-1:0]   cfg_ki,
  output logic [PRIO_W-1:0] req_prio_out
);
  logic              issue, busy, active;
  logic [CNT_W-1:0]  age, gap;
  logic [PRIO_W-1:0] level;
  adj_e              adj;

  assign issue  = req_valid && req_ready;
  assign active = cfg_override_en && cfg_reg_en;

  prio_outst_tracker #(.OUTST_W(OUTST_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .issue(issue), .done(rsp_done), .busy(busy), .age(age)
  );

  prio_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .issue(issue), .gap(gap)
  );

  always_comb begin
    adj = ADJ_HOLD;
    if (!cfg_period_mode) begin
      if (busy) adj = cmp_target(32'(age), 32'(cfg_target));
    end else begin
      if (busy)                  adj = cmp_target(32'(gap), 32'(cfg_target));
      else if (cfg_quiesce_high) adj = ADJ_UP;
    end
  end

  prio_accum #(.INT_W(PRIO_W), .FRAC_W(FRAC_W), .KI_W(KI_W)) u_acc (
    .clk(clk), .rst(rst), .active(active), .adj(adj),
    .ki(cfg_ki), .prog(cfg_prog_prio), .level(level)
  );

  always_comb begin
    if (!cfg_override_en) req_prio_out = req_prio_in;
    else if (!cfg_reg_en) req_prio_out = cfg_prog_prio;
    else                  req_prio_out = level;
  end

  // R6: idle normal-period regulation leaves the level untouched
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (active && cfg_period_mode && !cfg_quiesce_high && !busy) |=> $stable(level));

  // R11: latency measure with nothing outstanding holds the level
  p_lat_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (active && !cfg_period_mode && !busy) |=> $stable(level));

endmodule

// File: tb/prio_regulator_tb_top.sv
module prio_regulator_tb_top;
  localparam int CMAX = 65535;
  localparam int OMAX = 255;
  localparam int AMAX = 65535;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_ready = 0, rsp_done = 0;
  logic [3:0]  req_prio_in = 0;
  logic        cfg_override_en = 0, cfg_reg_en = 0, cfg_period_mode = 0, cfg_quiesce_high = 0;
  logic [3:0]  cfg_prog_prio = 0;
  logic [15:0] cfg_target = 0;
  logic [2:0]  cfg_ki = 0;
  logic [3:0]  req_prio_out;

  always #2 clk = ~clk;

  prio_regulator dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_done(rsp_done), .req_prio_in(req_prio_in),
    .cfg_override_en(cfg_override_en), .cfg_reg_en(cfg_reg_en),
    .cfg_period_mode(cfg_period_mode), .cfg_quiesce_high(cfg_quiesce_high),
    .cfg_prog_prio(cfg_prog_prio), .cfg_target(cfg_target), .cfg_ki(cfg_ki),
    .req_prio_out(req_prio_out)
  );

  int checks = 0, fails = 0;
  int m_acc = 0, m_out = 0, m_age = 0, m_gap = 0;
  bit finished = 0;

  function automatic int exp_out();
    if (!cfg_override_en) return int'(req_prio_in);
    if (!cfg_reg_en)      return int'(cfg_prog_prio);
    return m_acc >> 12;
  endfunction

  function automatic string mode_tag();
    if (!cfg_override_en)  return "R1";
    if (!cfg_reg_en)       return "R2";
    if (!cfg_period_mode)  return "R4";
    if (cfg_quiesce_high)  return "R7";
    return "R5";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One reference step: applies the inputs currently on the pins at the next edge.
  task automatic model_step();
    bit issue, inc, dec, busy;
    int step, dir;
    issue = req_valid && req_ready;
    inc   = issue && (m_out != OMAX);
    dec   = rsp_done && (m_out != 0);
    busy  = (m_out != 0);
    step  = 1 << cfg_ki;
    dir   = 0;
    if (!cfg_period_mode) begin
      if (busy) dir = (m_age > cfg_target) ? 1 : (m_age < cfg_target) ? -1 : 0;
    end else if (busy) begin
      dir = (m_gap > cfg_target) ? 1 : (m_gap < cfg_target) ? -1 : 0;
    end else if (cfg_quiesce_high) begin
      dir = 1;
    end
    if (rst) begin
      m_acc = int'(cfg_prog_prio) << 12; m_out = 0; m_age = 0; m_gap = 0;
    end else begin
      if (!(cfg_override_en && cfg_reg_en)) m_acc = int'(cfg_prog_prio) << 12;
      else if (dir > 0) m_acc = (m_acc + step > AMAX) ? AMAX : m_acc + step;
      else if (dir < 0) m_acc = (m_acc < step) ? 0 : m_acc - step;
      if (dec || m_out == 0) m_age = 0; else if (m_age != CMAX) m_age++;
      if (issue) m_gap = 0; else if (m_gap != CMAX) m_gap++;
      m_out = m_out + int'(inc) - int'(dec);
    end
  endtask

  // Inputs were set just after the falling edge; compare, advance, wait.
  task automatic tick();
    #1;
    if (!rst) check(mode_tag(), int'(req_prio_out), exp_out());
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_ready = 0; rsp_done = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    repeat (2) tick();
    rst = 0;
  endtask

  task automatic regulate(bit period, bit qh, int prog, int ki, int tgt);
    cfg_override_en = 1; cfg_reg_en = 1; cfg_period_mode = period;
    cfg_quiesce_high = qh; cfg_prog_prio = 4'(prog); cfg_ki = 3'(ki);
    cfg_target = 16'(tgt);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    regulate(0, 0, 5, 7, 0);
    do_reset();
    // R10: value right after reset
    #1 check("R10", int'(req_prio_out), 5);

    // R1: pass-through ignores the other configuration
    cfg_override_en = 0; req_prio_in = 4'd11;
    #1 check("R1", int'(req_prio_out), 11);
    tick();
    // R2: programmed constant
    cfg_override_en = 1; cfg_reg_en = 0; cfg_prog_prio = 4'd7; req_prio_in = 4'd1;
    #1 check("R2", int'(req_prio_out), 7);
    tick();

    // R11: latency measure, nothing outstanding: holds
    regulate(0, 0, 5, 7, 0);
    do_reset();
    repeat (100) tick();
    check("R11", int'(req_prio_out), 5);

    // R3/R8: one stuck transaction, step 2^-5, ~38 rises -> 6
    req_valid = 1; req_ready = 1; tick(); idle_inputs();
    repeat (39) tick();
    check("R3", int'(req_prio_out), 6);
    // R9: long stall saturates at 15
    repeat (600) tick();
    check("R9", int'(req_prio_out), 15);

    // R10: dropping regulation for one cycle reloads the programmed value
    cfg_reg_en = 0; tick(); cfg_reg_en = 1;
    #1 check("R10", int'(req_prio_out), 5);

    // R8: smallest step barely moves the level
    regulate(0, 0, 5, 0, 0);
    do_reset();
    req_valid = 1; req_ready = 1; tick(); idle_inputs();
    repeat (200) tick();
    check("R8", int'(req_prio_out), 5);

    // R6: normal period sub-mode idle holds
    regulate(1, 0, 9, 7, 10);
    do_reset();
    repeat (200) tick();
    check("R6", int'(req_prio_out), 9);
    // R7: quiesce-high idle rises to saturation
    cfg_quiesce_high = 1;
    repeat (600) tick();
    check("R7", int'(req_prio_out), 15);

    // R5/R9: back-to-back issues under a long period target fall to 0
    regulate(1, 0, 3, 7, 50);
    do_reset();
    for (int i = 0; i < 300; i++) begin
      req_valid = 1; req_ready = 1; rsp_done = (i > 2);
      tick();
    end
    idle_inputs();
    check("R5", int'(req_prio_out), 0);

    // Constrained random segments with per-cycle reference compare
    for (int s = 0; s < 30; s++) begin
      int vr, dr;
      cfg_override_en  = ($urandom_range(0, 9) != 0);
      cfg_reg_en       = ($urandom_range(0, 5) != 0);
      cfg_period_mode  = 1'($urandom_range(0, 1));
      cfg_quiesce_high = 1'($urandom_range(0, 1));
      cfg_prog_prio    = 4'($urandom_range(0, 15));
      cfg_ki           = 3'($urandom_range(3, 7));
      cfg_target       = 16'($urandom_range(0, 20));
      vr = $urandom_range(5, 60);
      dr = $urandom_range(5, 60);
      if (s % 5 == 0) do_reset();
      for (int c = 0; c < 400; c++) begin
        req_valid   = ($urandom_range(0, 99) < vr);
        req_ready   = ($urandom_range(0, 99) < 70);
        rsp_done    = ($urandom_range(0, 99) < dr);
        req_prio_in = 4'($urandom_range(0, 15));
        tick();
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule